// File: doc/BRIEF.md
# Three-Wire Half-Duplex SPI Master with Register and FIFO Chip Selects

This block is a single-request SPI master for a peripheral that shares one bidirectional data wire between both directions. It has a clock output and two active-low chip selects. One chip select frames register accesses. The other frames FIFO byte accesses. The data wire leaves the block as a data bit plus an output enable, so an external tri-state pad or the board can join them into one pin. The returned level comes back on a separate input.

A host raises `req_valid` for one cycle while the block is idle, with an opcode and, where the opcode needs them, an address and a write byte. Four operations are supported:

- A register write, sent as a 16-bit frame.
- A register read. The block sends 8 bits, turns the wire around and receives 8 bits.
- A single FIFO byte write.
- A single FIFO byte read.

The block reports completion with a one-cycle `done`. Read data stays on `rdata` until the next read completes. A multi-byte FIFO transfer is a series of single-byte requests, and each one gets its own chip-select frame and its own long deselect hold. The SPI clock is a divided clock enable set by `HALF_DIV`. The FIFO deselect hold is computed from `CLK_HZ` and `FIFO_HOLD_NS`.

Top module: `spi3w_master`

## Requirements
- R1: While `rst` is high and afterwards until a request is accepted, both chip selects are high, `spi_sck` is low, `sdio_oe` is low, `busy` and `done` are low, and `rdata` is 0.
- R2: Clocking is mode 0. `spi_sck` is low whenever both chip selects are high. `sdio_o` never changes on a rising edge of `spi_sck`. Every field is sent and received most significant bit first.
- R3: Opcode 2'b00 (register write) runs one `cs_reg_n` frame of 16 rising edges. `sdio_oe` is high at every rising edge. The bits are a 0 command bit, then `req_addr[6:0]`, then `req_wdata[7:0]`.
- R4: Opcode 2'b01 (register read) runs one `cs_reg_n` frame of 16 rising edges. A 1 command bit and `req_addr[6:0]` are driven with `sdio_oe` high at rises 1 to 8. `sdio_oe` drops on the falling edge after rise 8. `rdata` becomes the `sdio_i` levels seen at rises 9 to 16.
- R5: Opcode 2'b10 (FIFO write) runs one `cs_fifo_n` frame of 8 rising edges that carries only `req_wdata`, with `sdio_oe` high at each rise.
- R6: Opcode 2'b11 (FIFO read) runs one `cs_fifo_n` frame of 8 rising edges. `sdio_oe` stays low for the whole frame, and `rdata` becomes the 8 levels sampled.
- R7: `cs_reg_n` falls 2*HALF_DIV clock cycles (one SPI period) before the first rising edge. It rises 2*HALF_DIV cycles after the last falling edge.
- R8: `cs_fifo_n` falls 4*HALF_DIV cycles before the first rising edge. It rises max(ceil(FIFO_HOLD_NS*CLK_HZ/1e9), 2*HALF_DIV) cycles after the last falling edge, which is 250 cycles (2 us) at the defaults. Each FIFO request produces exactly one frame.
- R9: The two chip selects are never low together, and a chip select is low only while `busy` is high. `busy` is high from the cycle after acceptance until the chip select rises. A request made while busy is dropped and starts no frame.
- R10: `done` is high for exactly one cycle. It is raised on the same edge at which the chip select rises, and `busy` is low during that cycle.
- R11: `rdata` changes only on the edge that raises `done` for a read. Write operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, honoured only while idle |
| req_op | input | 2 | 00 reg write, 01 reg read, 10 FIFO write, 11 FIFO read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write byte for register or FIFO writes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Byte from the last completed read |
| spi_sck | output | 1 | SPI clock, idles low |
| cs_reg_n | output | 1 | Register-access chip select, active low |
| cs_fifo_n | output | 1 | FIFO-access chip select, active low |
| sdio_o | output | 1 | Data level driven onto the shared wire |
| sdio_oe | output | 1 | Drive enable for the shared wire |
| sdio_i | input | 1 | Level returned from the shared wire |

## Verification
The results of an accepted request arrive at different times:

- The chip select falls on the accepting edge, and `busy` is seen high one cycle after that edge.
- The first `spi_sck` rise follows 2*HALF_DIV or 4*HALF_DIV cycles after the chip select falls.
- The chip select rises 2*HALF_DIV or 250 cycles after the last falling edge.
- `done` and the new `rdata` appear on that same chip-select rise edge.

The bench drives inputs and samples outputs on the falling clock edge, and it waits on `done` rather than a fixed count. It timestamps the chip-select and clock edges, so setup and hold are compared in exact cycles. A peripheral model answers on falling SPI edges and captures the driven bits and drive enable on rising SPI edges.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;

  // Host opcodes; bit 1 selects the FIFO chip select, bit 0 selects reads.
  typedef enum logic [1:0] {
    OP_REG_WR  = 2'b00,
    OP_REG_RD  = 2'b01,
    OP_FIFO_WR = 2'b10,
    OP_FIFO_RD = 2'b11
  } spi3w_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD
  } spi3w_state_e;

endpackage

// File: rtl/spi3w_tick.sv
`timescale 1ns/1ps
// Half-period clock enable: pulses every HALF_DIV cycles while en is high.
module spi3w_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = en;
    end else begin : g_count
      localparam int TW = $clog2(HALF_DIV);
      logic [TW-1:0] cnt_q;

      assign tick = en && (cnt_q == TW'(HALF_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt_q <= '0;
        end else if (tick) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/spi3w_shift.sv
`timescale 1ns/1ps
// Frame shifter: left-aligned transmit word, serial receive byte.
module spi3w_shift #(
  parameter int FRAME_W = 16,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  input  logic               sample,
  input  logic               sdi,
  output logic               sdo,
  output logic [DW-1:0]      rx_byte
);

  logic [FRAME_W-1:0] tx_q;
  logic [DW-1:0]      rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
    end else if (shift) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {rx_q[DW-2:0], sdi};
    end
  end

  assign sdo     = tx_q[FRAME_W-1];
  assign rx_byte = rx_q;

endmodule

// File: rtl/spi3w_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: chip-select setup, bit clocking, turnaround, deselect hold.
module spi3w_ctrl import spi3w_pkg::*; #(
  parameter int HALF_DIV      = 4,
  parameter int FRAME_W       = 16,
  parameter int DW            = 8,
  parameter int FIFO_HOLD_CYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       tick,
  output logic       tick_en,
  output logic       load,
  output logic       shift,
  output logic       sample,
  output logic       fin_rd,
  output logic       busy,
  output logic       done,
  output logic       sck,
  output logic       cs_reg_n,
  output logic       cs_fifo_n,
  output logic       oe
);

  localparam int REG_SETUP  = HALF_DIV;
  localparam int FIFO_SETUP = 3 * HALF_DIV;
  localparam int REG_HOLD   = 2 * HALF_DIV;
  localparam int CNT_MAX    = (FIFO_HOLD_CYC > FIFO_SETUP) ? FIFO_HOLD_CYC : FIFO_SETUP;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam int BW         = $clog2(FRAME_W + 1);

  spi3w_state_e   state_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bits_q;
  logic           fifo_q;
  logic           rd_q;
  logic [CW-1:0]  setup_last;
  logic [CW-1:0]  hold_last;
  logic [BW-1:0]  nbits;
  logic           req_fifo;
  logic           req_rd;
  logic           hold_end;

  assign req_fifo   = (req_op == OP_FIFO_WR) || (req_op == OP_FIFO_RD);
  assign req_rd     = (req_op == OP_REG_RD)  || (req_op == OP_FIFO_RD);
  assign setup_last = fifo_q ? CW'(FIFO_SETUP - 1) : CW'(REG_SETUP - 1);
  assign hold_last  = fifo_q ? CW'(FIFO_HOLD_CYC - 1) : CW'(REG_HOLD - 1);
  assign nbits      = fifo_q ? BW'(DW) : BW'(FRAME_W);
  assign hold_end   = (state_q == ST_HOLD) && (cnt_q == hold_last);

  assign tick_en = (state_q == ST_XFER);
  assign load    = (state_q == ST_IDLE) && req_valid;
  assign shift   = tick_en && tick && sck && (bits_q != nbits);
  assign sample  = tick_en && tick && !sck && rd_q && (bits_q >= nbits - BW'(DW));
  assign fin_rd  = hold_end && rd_q;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bits_q    <= '0;
      fifo_q    <= 1'b0;
      rd_q      <= 1'b0;
      sck       <= 1'b0;
      cs_reg_n  <= 1'b1;
      cs_fifo_n <= 1'b1;
      oe        <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            fifo_q    <= req_fifo;
            rd_q      <= req_rd;
            cs_reg_n  <= req_fifo;
            cs_fifo_n <= !req_fifo;
            oe        <= (req_op != OP_FIFO_RD);
            cnt_q     <= '0;
            bits_q    <= '0;
            state_q   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt_q == setup_last) begin
            cnt_q   <= '0;
            state_q <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!sck) begin
              sck    <= 1'b1;
              bits_q <= bits_q + 1'b1;
            end else begin
              sck <= 1'b0;
              if (bits_q == nbits) begin
                oe      <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_HOLD;
              end else if (!fifo_q && rd_q && (bits_q == BW'(FRAME_W - DW))) begin
                oe <= 1'b0;
              end
            end
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            cs_reg_n  <= 1'b1;
            cs_fifo_n <= 1'b1;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi3w_master.sv
`timescale 1ns/1ps
module spi3w_master import spi3w_pkg::*; #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int HALF_DIV     = 4,
  parameter int FIFO_HOLD_NS = 2000,
  parameter int AW           = 7,
  parameter int DW           = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          spi_sck,
  output logic          cs_reg_n,
  output logic          cs_fifo_n,
  output logic          sdio_o,
  output logic          sdio_oe,
  input  logic          sdio_i
);

  localparam int FRAME_W       = 1 + AW + DW;
  localparam int HOLD_RAW      = ((CLK_HZ / 1000) * FIFO_HOLD_NS + 999_999) / 1_000_000;
  localparam int FIFO_HOLD_CYC = (HOLD_RAW > 2 * HALF_DIV) ? HOLD_RAW : 2 * HALF_DIV;

  logic               tick, tick_en;
  logic               load, shift, sample, fin_rd;
  logic [FRAME_W-1:0] load_word;
  logic [DW-1:0]      rx_byte;
  logic [DW-1:0]      rdata_q;

  always_comb begin
    unique case (spi3w_op_e'(req_op))
      OP_REG_WR:  load_word = {1'b0, req_addr, req_wdata};
      OP_REG_RD:  load_word = {1'b1, req_addr, {DW{1'b0}}};
      OP_FIFO_WR: load_word = {req_wdata, {(FRAME_W-DW){1'b0}}};
      default:    load_word = '0;
    endcase
  end

  spi3w_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (tick_en),
    .tick(tick)
  );

  spi3w_shift #(.FRAME_W(FRAME_W), .DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_word(load_word),
    .shift    (shift),
    .sample   (sample),
    .sdi      (sdio_i),
    .sdo      (sdio_o),
    .rx_byte  (rx_byte)
  );

  spi3w_ctrl #(
    .HALF_DIV     (HALF_DIV),
    .FRAME_W      (FRAME_W),
    .DW           (DW),
    .FIFO_HOLD_CYC(FIFO_HOLD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .tick     (tick),
    .tick_en  (tick_en),
    .load     (load),
    .shift    (shift),
    .sample   (sample),
    .fin_rd   (fin_rd),
    .busy     (busy),
    .done     (done),
    .sck      (spi_sck),
    .cs_reg_n (cs_reg_n),
    .cs_fifo_n(cs_fifo_n),
    .oe       (sdio_oe)
  );

  // Read result is captured on the edge that raises done.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (fin_rd) begin
      rdata_q <= rx_byte;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/spi3w_master_chk.sv
`timescale 1ns/1ps
module spi3w_master_chk #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int HALF_DIV     = 4,
  parameter int FIFO_HOLD_NS = 2000,
  parameter int DW           = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          spi_sck,
  input logic          cs_reg_n,
  input logic          cs_fifo_n,
  input logic          sdio_o,
  input logic          sdio_oe
);

  localparam int REG_HOLD_MIN  = 2 * HALF_DIV;
  localparam int HOLD_RAW      = ((CLK_HZ / 1000) * FIFO_HOLD_NS + 999_999) / 1_000_000;
  localparam int FIFO_HOLD_MIN = (HOLD_RAW > REG_HOLD_MIN) ? HOLD_RAW : REG_HOLD_MIN;

  // Cycles since spi_sck was last seen high, saturating.
  logic [31:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || spi_sck) begin
      gap_q <= '0;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_cs_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(!cs_reg_n && !cs_fifo_n));
  p_cs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (!cs_reg_n || !cs_fifo_n) |-> busy);
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_reg_n && cs_fifo_n) |-> !spi_sck);
  p_sdo_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> $stable(sdio_o));
  p_oe_frame_r4: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> (!cs_reg_n || !cs_fifo_n));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));
  p_reg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_reg_n) |-> (gap_q >= 32'(REG_HOLD_MIN)));
  p_fifo_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_fifo_n) |-> (gap_q >= 32'(FIFO_HOLD_MIN)));

endmodule

bind spi3w_master spi3w_master_chk #(
  .CLK_HZ      (CLK_HZ),
  .HALF_DIV    (HALF_DIV),
  .FIFO_HOLD_NS(FIFO_HOLD_NS),
  .DW          (DW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .rdata    (rdata),
  .spi_sck  (spi_sck),
  .cs_reg_n (cs_reg_n),
  .cs_fifo_n(cs_fifo_n),
  .sdio_o   (sdio_o),
  .sdio_oe  (sdio_oe)
);

// File: tb/tb_spi3w_master.sv
`timescale 1ns/1ps
module tb_spi3w_master;

  localparam int HALF_DIV  = 4;
  localparam int CLK_NS    = 8;
  localparam int REG_SU_NS  = 2 * HALF_DIV * CLK_NS;
  localparam int FIFO_SU_NS = 4 * HALF_DIV * CLK_NS;
  localparam int REG_HD_NS  = 2 * HALF_DIV * CLK_NS;
  localparam int FIFO_HD_NS = 2000;
  localparam int NVEC = 8;

  // {op[1:0], addr[6:0], wdata[7:0], peripheral response[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {2'b00, 7'h12, 8'hA5, 8'h00},
    {2'b01, 7'h7F, 8'h00, 8'h3C},
    {2'b10, 7'h00, 8'h81, 8'h00},
    {2'b11, 7'h00, 8'h00, 8'hC3},
    {2'b00, 7'h00, 8'hFF, 8'h00},
    {2'b01, 7'h00, 8'h00, 8'h01},
    {2'b11, 7'h00, 8'h00, 8'h80},
    {2'b10, 7'h00, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [1:0] req_op;
  logic [6:0] req_addr;
  logic [7:0] req_wdata;
  logic       busy, done;
  logic [7:0] rdata;
  logic       spi_sck, cs_reg_n, cs_fifo_n, sdio_o, sdio_oe;
  logic       sdio_i;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi3w_master #(.CLK_HZ(125_000_000), .HALF_DIV(HALF_DIV), .FIFO_HOLD_NS(2000)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .spi_sck(spi_sck), .cs_reg_n(cs_reg_n), .cs_fifo_n(cs_fifo_n),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  // Peripheral model and pin monitor
  int          rise_cnt = 0;
  int          frame_cnt = 0;
  int          resp_start = 0;
  logic [7:0]  resp = 8'h00;
  logic [15:0] cap_o = '0;
  logic [15:0] cap_oe = '0;
  bit          last_fifo = 1'b0;
  time         t_csf = 0, t_r1 = 0, t_lf = 0, t_csr = 0;
  int          overlap_err = 0;
  int          sck_err = 0;

  always @(negedge cs_reg_n or negedge cs_fifo_n) begin
    frame_cnt++;
    last_fifo = !cs_fifo_n;
    rise_cnt  = 0;
    cap_o     = '0;
    cap_oe    = '0;
    t_csf     = $time;
    if (resp_start == 0) sdio_i = resp[7];
  end

  always @(posedge spi_sck) begin
    if (rise_cnt == 0) t_r1 = $time;
    cap_o  = {cap_o[14:0], sdio_o};
    cap_oe = {cap_oe[14:0], sdio_oe};
    rise_cnt++;
  end

  always @(negedge spi_sck) begin
    t_lf = $time;
    if (rise_cnt >= resp_start && rise_cnt < resp_start + 8)
      sdio_i = resp[7 - (rise_cnt - resp_start)];
  end

  always @(posedge cs_reg_n or posedge cs_fifo_n) t_csr = $time;

  always @(negedge clk) begin
    if (rst === 1'b0) begin
      if (!cs_reg_n && !cs_fifo_n) overlap_err++;
      if (cs_reg_n && cs_fifo_n && spi_sck) sck_err++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [6:0] addr,
                       input logic [7:0] wd, input logic [7:0] rsp);
    int n;
    resp       = rsp;
    resp_start = (op == 2'b01) ? 8 : 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 1);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 5000, "R10", "done reached", 32'(n), 0);
    chk(busy == 1'b0, "R10", "busy low with done", 32'(busy), 0);
  endtask

  task automatic done_width();
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", 32'(done), 0);
  endtask

  logic [1:0] v_op;
  logic [6:0] v_addr;
  logic [7:0] v_wd, v_rsp;
  logic [7:0] exp_rd;
  int         fc0;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_wdata = '0;
    sdio_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_reg_n && cs_fifo_n, "R1", "chip selects idle", {30'd0, cs_reg_n, cs_fifo_n}, 3);
    chk(!spi_sck && !sdio_oe, "R1", "sck/oe idle", {30'd0, spi_sck, sdio_oe}, 0);
    chk(!busy && !done, "R1", "busy/done idle", {30'd0, busy, done}, 0);
    chk(rdata == 8'h00, "R1", "rdata reset", 32'(rdata), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_reg_n && cs_fifo_n && !busy, "R1", "idle after reset",
        {29'd0, cs_reg_n, cs_fifo_n, busy}, 6);
    exp_rd = 8'h00;

    for (int i = 0; i < NVEC; i++) begin
      v_op = VEC[i][24:23]; v_addr = VEC[i][22:16]; v_wd = VEC[i][15:8]; v_rsp = VEC[i][7:0];
      fc0 = frame_cnt;
      issue(v_op, v_addr, v_wd, v_rsp);
      if (v_op[0]) exp_rd = v_rsp;
      chk(frame_cnt == fc0 + 1, "R8", "one frame per request", 32'(frame_cnt - fc0), 1);
      chk(rdata == exp_rd, "R11", "rdata after op", 32'(rdata), 32'(exp_rd));
      case (v_op)
        2'b00: begin
          chk(!last_fifo && rise_cnt == 16, "R3", "reg write cs/edges", 32'(rise_cnt), 16);
          chk(cap_o == {1'b0, v_addr, v_wd}, "R3", "reg write bits", 32'(cap_o),
              32'({1'b0, v_addr, v_wd}));
          chk(cap_oe == 16'hFFFF, "R3", "reg write oe", 32'(cap_oe), 32'hFFFF);
        end
        2'b01: begin
          chk(!last_fifo && rise_cnt == 16, "R4", "reg read cs/edges", 32'(rise_cnt), 16);
          chk(cap_o[15:8] == {1'b1, v_addr}, "R4", "reg read header", 32'(cap_o[15:8]),
              32'({1'b1, v_addr}));
          chk(cap_oe == 16'hFF00, "R4", "reg read turnaround", 32'(cap_oe), 32'hFF00);
          chk(rdata == v_rsp, "R4", "reg read data", 32'(rdata), 32'(v_rsp));
        end
        2'b10: begin
          chk(last_fifo && rise_cnt == 8, "R5", "fifo write cs/edges", 32'(rise_cnt), 8);
          chk(cap_o[7:0] == v_wd, "R5", "fifo write bits", 32'(cap_o[7:0]), 32'(v_wd));
          chk(cap_oe[7:0] == 8'hFF, "R5", "fifo write oe", 32'(cap_oe[7:0]), 32'hFF);
        end
        default: begin
          chk(last_fifo && rise_cnt == 8, "R6", "fifo read cs/edges", 32'(rise_cnt), 8);
          chk(cap_oe[7:0] == 8'h00, "R6", "fifo read oe low", 32'(cap_oe[7:0]), 0);
          chk(rdata == v_rsp, "R6", "fifo read data", 32'(rdata), 32'(v_rsp));
        end
      endcase
      if (!last_fifo) begin
        chk((t_r1 - t_csf) == REG_SU_NS, "R7", "reg cs setup ns", 32'(t_r1 - t_csf), REG_SU_NS);
        chk((t_csr - t_lf) == REG_HD_NS, "R7", "reg cs hold ns", 32'(t_csr - t_lf), REG_HD_NS);
      end else begin
        chk((t_r1 - t_csf) == FIFO_SU_NS, "R8", "fifo cs setup ns", 32'(t_r1 - t_csf), FIFO_SU_NS);
        chk((t_csr - t_lf) == FIFO_HD_NS, "R8", "fifo cs hold ns", 32'(t_csr - t_lf), FIFO_HD_NS);
      end
      done_width();
    end

    // R9: a request made while busy is dropped
    fc0 = frame_cnt;
    resp = 8'h00; resp_start = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_addr = 7'h2A; req_wdata = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(frame_cnt == fc0 + 1, "R9", "busy request dropped", 32'(frame_cnt - fc0), 1);
    chk(cap_o == {1'b0, 7'h2A, 8'h55} && !last_fifo, "R9", "first request intact",
        32'(cap_o), 32'({1'b0, 7'h2A, 8'h55}));
    chk(!busy, "R9", "idle afterwards", 32'(busy), 0);
    chk(rdata == exp_rd, "R11", "rdata kept over write", 32'(rdata), 32'(exp_rd));

    chk(overlap_err == 0, "R9", "chip selects overlap", 32'(overlap_err), 0);
    chk(sck_err == 0, "R2", "sck high while deselected", 32'(sck_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule